// File: doc/BRIEF.md
# Interrupt Acknowledge Opcode Jammer

This block sits beside an 8-bit processor on the shared data bus. It collects up to eight peripheral service requests, each with its own enable, and folds them into one level-sensitive interrupt request line. When the processor answers with an active-low acknowledge strobe, the block places a byte on the bus. The processor takes that byte in as if it were an instruction fetch, and the byte sends execution to the service routine of the winning source.

There are two jamming styles, chosen by a mode input. In restart mode a single strobe delivers a one-byte restart opcode that names the source. In call mode three strobes in a row deliver a call opcode, then the low byte and then the high byte of a 16-bit service address. Each source's address is held in a small table that a configuration write port loads. The winning source and the mode are captured on the first strobe of a sequence. The source's pending bit is released only once its last byte has been delivered, and the request line is then evaluated again from whatever is still waiting.

Top module: `inta_jammer`

## Requirements
- R1: A request input that is high at a rising clock edge sets that source's pending bit. The bit stays set until that source's acknowledge sequence completes. `intr` is high whenever no sequence is in progress and at least one pending source is enabled.
- R2: A pending source whose enable bit is 0 neither raises `intr` nor wins a strobe. It stays pending and raises `intr` once it is enabled.
- R3: Among enabled pending sources, the lowest index wins.
- R4: In restart mode (`call_mode` = 0), one strobe delivers the byte 11NNN111, where NNN is the 3-bit source index (source n gives C7h + 8·n). That strobe completes the sequence.
- R5: In call mode (`call_mode` = 1), three strobes deliver CDh, then bits 7:0 of the source's service address, then bits 15:8.
- R6: `bus_oe` is high exactly while `inta_n` is low. While a strobe serves a real source, `ack_vld` is 1 and `ack_id` holds that source's index.
- R7: The source and mode are captured on the first clock edge that sees `inta_n` low in a new sequence, and they hold until the sequence ends. From the clock after that edge until completion, `intr` is 0.
- R8: The winning source's pending bit clears on the clock edge that sees `inta_n` rise after its last byte. After that edge, `intr` again reflects the remaining enabled pending sources.
- R9: A strobe that arrives with no enabled pending source drives FFh with `ack_vld` = 0. It is a single-strobe sequence in both modes and clears no pending bit.
- R10: A clock edge with `cfg_we` = 1 loads `cfg_addr` as the service address of source `cfg_sel`. Reset sets every address to 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | 8 | Per-source request inputs |
| req_en | input | 8 | Per-source enables |
| call_mode | input | 1 | 0 = restart opcode, 1 = three-byte call |
| cfg_we | input | 1 | Service address write strobe |
| cfg_sel | input | 3 | Source whose address is written |
| cfg_addr | input | 16 | Service address to write |
| inta_n | input | 1 | Active-low acknowledge strobe, synchronous to clk |
| intr | output | 1 | Interrupt request to the processor |
| bus_out | output | 8 | Byte driven onto the data bus |
| bus_oe | output | 1 | Data bus drive enable |
| ack_vld | output | 1 | Current strobe serves a real source |
| ack_id | output | 3 | Index of the source being acknowledged |

## Verification
A stuck or miscounted byte phase shows up at once as a wrong byte in the very strobe where the phase is wrong. A lost completion shows up one strobe later, because `intr` never returns and the next sequence starts in the wrong phase. A pending bit that clears too early or too late is caught right after the rising edge of the last strobe, where `intr` must match the enabled sources that remain. A captured source that drifts is caught in the second or third call strobe: the bench raises a higher-priority request partway through the sequence, so drift changes the address byte and `ack_id`.

// File: rtl/ijam_pkg.sv
package ijam_pkg;

    localparam int          BYTE_W   = 8;
    localparam logic [7:0]  CALL_OP  = 8'hCD;
    localparam logic [7:0]  IDLE_OP  = 8'hFF;

    typedef enum logic {
        MODE_RST  = 1'b0,
        MODE_CALL = 1'b1
    } jam_mode_e;

    typedef enum logic [1:0] {
        PH_OP = 2'd0,
        PH_LO = 2'd1,
        PH_HI = 2'd2
    } phase_e;

    // one-byte restart: two ones, source index, three ones
    function automatic logic [7:0] restart_op(input logic [2:0] n);
        return {2'b11, n, 3'b111};
    endfunction

endpackage

// File: rtl/ijam_pend.sv
module ijam_pend #(
    parameter int N_SRC = 8,
    localparam int ID_W = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] req,
    input  logic [N_SRC-1:0] en,
    input  logic             clr_vld,
    input  logic [ID_W-1:0]  clr_id,
    output logic [N_SRC-1:0] pend,
    output logic             any,
    output logic [ID_W-1:0]  pick_id
);
    logic [N_SRC-1:0] live;
    logic [N_SRC-1:0] clr_mask;

    for (genvar g = 0; g < N_SRC; g++) begin : g_clr
        assign clr_mask[g] = clr_vld && (clr_id == ID_W'(g));
    end

    assign live = pend & en;
    assign any  = |live;

    // lowest index wins
    always_comb begin
        pick_id = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (live[i]) pick_id = ID_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= (pend & ~clr_mask) | req;
    end
endmodule

// File: rtl/ijam_vtab.sv
module ijam_vtab #(
    parameter int N_SRC  = 8,
    parameter int ADDR_W = 16,
    localparam int ID_W  = $clog2(N_SRC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ID_W-1:0]   wr_id,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ID_W-1:0]   rd_id,
    output logic [ADDR_W-1:0] rd_addr
);
    logic [ADDR_W-1:0] tab [N_SRC];

    for (genvar g = 0; g < N_SRC; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)                                  tab[g] <= '0;
            else if (wr_en && wr_id == ID_W'(g))      tab[g] <= wr_addr;
        end
    end

    assign rd_addr = tab[rd_id];
endmodule

// File: rtl/ijam_seq.sv
module ijam_seq
    import ijam_pkg::*;
#(
    parameter int N_SRC  = 8,
    parameter int ADDR_W = 16,
    localparam int ID_W  = $clog2(N_SRC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inta_n,
    input  logic              mode_in,
    input  logic              any,
    input  logic [ID_W-1:0]   pick_id,
    input  logic [ADDR_W-1:0] svc_addr,
    output logic [ID_W-1:0]   cur_id,
    output jam_mode_e         eff_mode,
    output phase_e            phase,
    output logic              busy,
    output logic              intr,
    output logic [7:0]        bus_out,
    output logic              bus_oe,
    output logic              ack_vld,
    output logic              clr_vld,
    output logic [ID_W-1:0]   clr_id
);
    logic            inta_q;
    logic            hit_q;
    jam_mode_e       mode_q;
    logic [ID_W-1:0] src_q;
    logic            fall, rise, cur_hit, last;

    assign fall     = ~inta_n & inta_q;
    assign rise     = inta_n & ~inta_q;

    assign cur_id   = busy ? src_q : pick_id;
    assign cur_hit  = busy ? hit_q : any;
    assign eff_mode = busy ? mode_q : jam_mode_e'(mode_in);
    assign last     = !cur_hit || eff_mode == MODE_RST || phase == PH_HI;

    assign intr     = ~busy & any;
    assign bus_oe   = ~inta_n;
    assign ack_vld  = ~inta_n & cur_hit;
    assign clr_vld  = rise & busy & last & hit_q;
    assign clr_id   = src_q;

    always_comb begin
        if (!cur_hit)                 bus_out = IDLE_OP;
        else if (eff_mode == MODE_RST) bus_out = restart_op(3'(cur_id));
        else begin
            unique case (phase)
                PH_LO:   bus_out = svc_addr[7:0];
                PH_HI:   bus_out = svc_addr[15:8];
                default: bus_out = CALL_OP;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            inta_q <= 1'b1;
            busy   <= 1'b0;
            hit_q  <= 1'b0;
            mode_q <= MODE_RST;
            src_q  <= '0;
            phase  <= PH_OP;
        end else begin
            inta_q <= inta_n;
            if (fall && !busy) begin
                busy   <= 1'b1;
                hit_q  <= any;
                src_q  <= pick_id;
                mode_q <= jam_mode_e'(mode_in);
            end
            if (rise && busy) begin
                if (last) begin
                    busy  <= 1'b0;
                    phase <= PH_OP;
                end else begin
                    phase <= phase_e'(phase + 2'd1);
                end
            end
        end
    end
endmodule

// File: rtl/inta_jammer.sv
module inta_jammer
    import ijam_pkg::*;
#(
    parameter int N_SRC  = 8,
    parameter int ADDR_W = 16,
    localparam int ID_W  = $clog2(N_SRC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  req_in,
    input  logic [N_SRC-1:0]  req_en,
    input  logic              call_mode,
    input  logic              cfg_we,
    input  logic [ID_W-1:0]   cfg_sel,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              inta_n,
    output logic              intr,
    output logic [7:0]        bus_out,
    output logic              bus_oe,
    output logic              ack_vld,
    output logic [ID_W-1:0]   ack_id
);
    logic [N_SRC-1:0]  pend_w;
    logic              any_w;
    logic [ID_W-1:0]   pick_w;
    logic [ADDR_W-1:0] svc_w;
    logic              clr_vld_w;
    logic [ID_W-1:0]   clr_id_w;
    jam_mode_e         seq_mode;
    phase_e            seq_phase;
    logic              seq_busy;

    ijam_pend #(.N_SRC(N_SRC)) u_pend (
        .clk(clk), .rst(rst), .req(req_in), .en(req_en),
        .clr_vld(clr_vld_w), .clr_id(clr_id_w),
        .pend(pend_w), .any(any_w), .pick_id(pick_w)
    );

    ijam_vtab #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_vtab (
        .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_id(cfg_sel),
        .wr_addr(cfg_addr), .rd_id(ack_id), .rd_addr(svc_w)
    );

    ijam_seq #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst(rst), .inta_n(inta_n), .mode_in(call_mode),
        .any(any_w), .pick_id(pick_w), .svc_addr(svc_w),
        .cur_id(ack_id), .eff_mode(seq_mode), .phase(seq_phase),
        .busy(seq_busy), .intr(intr), .bus_out(bus_out), .bus_oe(bus_oe),
        .ack_vld(ack_vld), .clr_vld(clr_vld_w), .clr_id(clr_id_w)
    );
endmodule

// File: rtl/ijam_chk.sv
module ijam_chk
    import ijam_pkg::*;
#(
    parameter int N_SRC = 8,
    localparam int ID_W = $clog2(N_SRC)
) (
    input logic             clk,
    input logic             rst,
    input logic             inta_n,
    input logic             intr,
    input logic [7:0]       bus_out,
    input logic             bus_oe,
    input logic             ack_vld,
    input logic [ID_W-1:0]  ack_id,
    input logic [N_SRC-1:0] req_en,
    input logic [N_SRC-1:0] pend,
    input logic             busy,
    input jam_mode_e        mode,
    input phase_e           phase
);
    // R7
    intr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(inta_n) |=> !intr);

    // R4
    restart_form_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_vld && mode == MODE_RST) |->
            (bus_out[7:6] == 2'b11 && bus_out[2:0] == 3'b111 && bus_out[5:3] == 3'(ack_id)));

    // R5
    call_opcode_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_vld && mode == MODE_CALL && phase == PH_OP) |-> bus_out == CALL_OP);

    // R3
    lowest_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_vld && !busy) |->
            ((pend & req_en & ((N_SRC'(1) << ack_id) - N_SRC'(1))) == '0));

    // R9
    spurious_ff_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_oe && !ack_vld) |-> bus_out == IDLE_OP);
endmodule

bind inta_jammer ijam_chk #(.N_SRC(N_SRC)) u_chk (
    .clk(clk), .rst(rst), .inta_n(inta_n), .intr(intr), .bus_out(bus_out),
    .bus_oe(bus_oe), .ack_vld(ack_vld), .ack_id(ack_id), .req_en(req_en),
    .pend(pend_w), .busy(seq_busy), .mode(seq_mode), .phase(seq_phase)
);

// File: tb/sim_inta_jammer.sv
module sim_inta_jammer;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  req_in = '0;
    logic [7:0]  req_en = '0;
    logic        call_mode = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [15:0] cfg_addr = '0;
    logic        inta_n = 1'b1;
    logic        intr, bus_oe, ack_vld;
    logic [7:0]  bus_out;
    logic [2:0]  ack_id;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    inta_jammer u0 (
        .clk(clk), .rst(rst), .req_in(req_in), .req_en(req_en),
        .call_mode(call_mode), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_addr(cfg_addr), .inta_n(inta_n), .intr(intr), .bus_out(bus_out),
        .bus_oe(bus_oe), .ack_vld(ack_vld), .ack_id(ack_id)
    );

    typedef struct packed {
        logic       call;
        logic [7:0] req;
        logic [7:0] en;
        logic [2:0] id;
        logic       intr_after;
    } vec_t;

    localparam vec_t TBL [6] = '{
        '{1'b0, 8'h01, 8'hFF, 3'd0, 1'b0},
        '{1'b0, 8'h28, 8'hFF, 3'd3, 1'b1},
        '{1'b1, 8'h90, 8'hFF, 3'd4, 1'b1},
        '{1'b1, 8'h06, 8'hFC, 3'd2, 1'b0},
        '{1'b0, 8'h80, 8'h80, 3'd7, 1'b0},
        '{1'b1, 8'hFF, 8'h0F, 3'd0, 1'b1}
    };

    function automatic logic [15:0] svc(input int i);
        return 16'(16'hA030 + i * 16'h0111);
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; inta_n = 1'b1; req_in = '0;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic program_tab();
        for (int i = 0; i < 8; i++) begin
            cfg_we = 1'b1; cfg_sel = 3'(i); cfg_addr = svc(i);
            @(negedge clk);
        end
        cfg_we = 1'b0;
    endtask

    task automatic pulse_req(input logic [7:0] m);
        req_in = m; @(negedge clk); req_in = '0; #1;
    endtask

    // one strobe: sampled while low, then raised; returns after the rising edge is seen
    task automatic strobe(output logic [7:0] b, output logic [2:0] id,
                          output logic v, output logic oe);
        inta_n = 1'b0; #1;
        b = bus_out; id = ack_id; v = ack_vld; oe = bus_oe;
        @(negedge clk); inta_n = 1'b1; #1;
        check("R6 oe off", 16'(bus_oe), 16'd0);
        @(negedge clk); #1;
    endtask

    initial begin
        #(CLK_P * 100000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] b; logic [2:0] id; logic v, oe;

        do_reset(); #1;
        check("R1 reset intr", 16'(intr), 16'd0);
        check("R6 reset oe", 16'(bus_oe), 16'd0);
        check("R6 reset vld", 16'(ack_vld), 16'd0);

        // table walk: R1 R3 R4 R5 R8
        foreach (TBL[k]) begin
            do_reset();
            program_tab();
            req_en = TBL[k].en; call_mode = TBL[k].call;
            pulse_req(TBL[k].req);
            check("R1 intr raised", 16'(intr), 16'd1);
            strobe(b, id, v, oe);
            check("R6 oe on", 16'(oe), 16'd1);
            check("R3 winner", 16'(id), 16'(TBL[k].id));
            check("R6 ack_vld", 16'(v), 16'd1);
            if (!TBL[k].call) begin
                check("R4 restart byte", 16'(b), 16'(8'hC7 + 8 * TBL[k].id));
            end else begin
                check("R5 call opcode", 16'(b), 16'hCD);
                check("R7 intr quiet", 16'(intr), 16'd0);
                strobe(b, id, v, oe);
                check("R5 low byte", 16'(b), 16'(svc(int'(TBL[k].id)) & 16'h00FF));
                strobe(b, id, v, oe);
                check("R5 high byte", 16'(b), 16'(svc(int'(TBL[k].id)) >> 8));
            end
            check("R8 intr after", 16'(intr), 16'(TBL[k].intr_after));
        end

        // R10: reset zeroes the table
        do_reset();
        req_en = 8'hFF; call_mode = 1'b1;
        pulse_req(8'h04);
        strobe(b, id, v, oe);
        strobe(b, id, v, oe);
        check("R10 reset low", 16'(b), 16'h00);
        strobe(b, id, v, oe);
        check("R10 reset high", 16'(b), 16'h00);

        // R2: disabled source stays pending
        do_reset();
        req_en = 8'h00; call_mode = 1'b0;
        pulse_req(8'h20);
        check("R2 masked intr", 16'(intr), 16'd0);
        req_en = 8'hFF; #1;
        check("R2 enabled later", 16'(intr), 16'd1);
        strobe(b, id, v, oe);
        check("R2 later byte", 16'(b), 16'hEF);
        check("R8 cleared", 16'(intr), 16'd0);

        // R7: capture holds against a later higher-priority request
        do_reset();
        program_tab();
        req_en = 8'hFF; call_mode = 1'b1;
        pulse_req(8'h20);
        strobe(b, id, v, oe);
        check("R7 first id", 16'(id), 16'd5);
        pulse_req(8'h01);
        check("R7 quiet mid", 16'(intr), 16'd0);
        call_mode = 1'b0;
        strobe(b, id, v, oe);
        check("R7 frozen id", 16'(id), 16'd5);
        check("R7 frozen low", 16'(b), 16'(svc(5) & 16'h00FF));
        strobe(b, id, v, oe);
        check("R7 frozen high", 16'(b), 16'(svc(5) >> 8));
        check("R8 reeval", 16'(intr), 16'd1);
        strobe(b, id, v, oe);
        check("R8 next restart", 16'(b), 16'hC7);
        check("R8 all done", 16'(intr), 16'd0);

        // R9: spurious strobe in call mode, masked pending survives
        do_reset();
        program_tab();
        req_en = 8'h00; call_mode = 1'b1;
        pulse_req(8'h04);
        strobe(b, id, v, oe);
        check("R9 idle byte", 16'(b), 16'hFF);
        check("R9 no ack", 16'(v), 16'd0);
        check("R9 oe on", 16'(oe), 16'd1);
        req_en = 8'hFF; #1;
        check("R9 not cleared", 16'(intr), 16'd1);
        strobe(b, id, v, oe);
        check("R9 fresh sequence", 16'(b), 16'hCD);
        check("R9 fresh id", 16'(id), 16'd2);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule